// File: doc/BRIEF.md
# Deferred-Fault Load Check and In-Order Retirement

This block sits between load execution and architectural commit. A permission check stage receives each finished load together with its translation lookup outcome. When the lookup hits but the access is forbidden, the load is not held back: it completes in the same cycle with its data forced to zero, so that nothing depending on it can consume the protected value. Its buffer entry is tagged to fault later. When the lookup misses, the check stage parks the load in a wait state until a page-walk response arrives. A failed walk is handled like a permission fault: zero data, with the fault deferred.

A small circular buffer holds every dispatched operation in program order. Stores count as complete when they are dispatched, but the commit release for a store is given only in the cycle that store retires. Up to four completed entries retire per cycle, starting from the oldest. Retirement stops at the first entry that is incomplete or tagged to fault. A tagged entry raises the exception only once it is the oldest entry. In that cycle every entry is discarded, including stores not yet released, and allocation restarts at the faulting entry's tag.

The check stage has two states. `CHK_IDLE` accepts loads. It moves to `CHK_WALK` on a load whose lookup missed. `CHK_WALK` returns to `CHK_IDLE` when the walk response arrives, or when a flush abandons the waiting load.

Top module: `defer_fault_rob`

## Requirements
- R1: After reset `disp_ready` is 1, `ld_ready` is 1, `ret_cnt` is 0, `exc_valid` is 0 and `disp_tag` is 0. Accepted dispatches receive consecutive tags modulo the depth of 8.
- R2: With 8 entries occupied, `disp_ready` is 0, and a dispatch offered while it is 0 allocates nothing.
- R3: A load with `ld_hit`=1 and `ld_perm_ok`=0 completes in the same cycle: `ld_ready` stays 1, `wb_valid` is 1, `wb_data` is all zeros, and the entry is tagged to fault.
- R4: A load with `ld_hit`=1 and `ld_perm_ok`=1 completes in the same cycle with `wb_data` equal to `ld_data`.
- R5: A load with `ld_hit`=0 produces no completion. `ld_ready` is 0 from the next cycle until the cycle in which `walk_valid` is 1. In that cycle the load completes with its tag, and if `walk_ok`=1 its data is the data captured with the request.
- R6: A walk response with `walk_ok`=0 completes the load with zero data and tags its entry to fault.
- R7: Each cycle, `ret_cnt` entries starting at tag `ret_base_tag` retire. `ret_cnt` is at most 4 and covers only the leading run of complete, untagged entries from the oldest. An incomplete oldest entry gives `ret_cnt`=0.
- R8: `exc_valid` is 1 with `exc_tag` equal to the entry's tag only when the tagged entry is the oldest. Older complete entries retire in an earlier cycle, and `ret_cnt` is 0 while `exc_valid` is 1.
- R9: When several entries are tagged, the exception names the oldest of them, even if a younger one completed first.
- R10: In the exception cycle `disp_ready` is 0 and all entries are discarded; no discarded store is ever released. The next dispatch receives the faulting tag.
- R11: `st_release` bit i is 1 only when the entry `ret_base_tag`+i is a store retiring in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_store | input | 1 | Dispatched operation is a store |
| disp_ready | output | 1 | Buffer accepts a dispatch this cycle |
| disp_tag | output | 3 | Tag given to the dispatch this cycle |
| ld_valid | input | 1 | Load result presented for checking |
| ld_ready | output | 1 | Check stage can take a load |
| ld_tag | input | 3 | Buffer tag of the load |
| ld_data | input | 32 | Raw loaded data |
| ld_hit | input | 1 | Translation entry found |
| ld_perm_ok | input | 1 | Found entry permits the access |
| walk_valid | input | 1 | Page-walk response |
| walk_ok | input | 1 | Walk produced a permitted translation |
| wb_valid | output | 1 | Load writeback valid |
| wb_tag | output | 3 | Writeback tag |
| wb_data | output | 32 | Writeback data, zero on a fault |
| ret_cnt | output | 3 | Number of entries retiring this cycle |
| ret_base_tag | output | 3 | Tag of the oldest retiring entry |
| st_release | output | 4 | Per-lane store commit release |
| exc_valid | output | 1 | Deferred fault raised |
| exc_tag | output | 3 | Tag of the faulting entry |

## Verification
The hardest case to reach is two tagged loads that complete out of order behind an older, still-incomplete load. Here the exception must wait for the older load to retire and must then name the older of the two tagged entries. The stimulus dispatches three loads, completes the youngest with a denied permission, then the middle one the same way, and completes the oldest last. The bench checks that no exception appears until the oldest has retired, and then confirms which tag is reported. A second hard case is the full buffer with an extra store offered: it is judged only by the total that later retires.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
    localparam int DFR_DEPTH_DEF  = 8;
    localparam int DFR_RET_W_DEF  = 4;
    localparam int DFR_DATA_W_DEF = 32;

    typedef enum logic [0:0] {
        CHK_IDLE = 1'b0,
        CHK_WALK = 1'b1
    } chk_state_e;
endpackage

// File: rtl/dfr_ldchk.sv
module dfr_ldchk
    import dfr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [IDX_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_hit,
    input  logic              ld_perm_ok,
    input  logic              walk_valid,
    input  logic              walk_ok,
    output logic              cmp_valid,
    output logic [IDX_W-1:0]  cmp_tag,
    output logic              cmp_fault,
    output logic [DATA_W-1:0] wb_data
);
    chk_state_e        state, state_n;
    logic [IDX_W-1:0]  park_tag;
    logic [DATA_W-1:0] park_data;

    // state register and parked request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= CHK_IDLE;
            park_tag  <= '0;
            park_data <= '0;
        end else begin
            state <= state_n;
            if (state == CHK_IDLE && ld_valid && !ld_hit) begin
                park_tag  <= ld_tag;
                park_data <= ld_data;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            CHK_IDLE: if (ld_valid && !ld_hit && !flush) state_n = CHK_WALK;
            CHK_WALK: if (walk_valid || flush)           state_n = CHK_IDLE;
            default:  state_n = CHK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ld_ready  = (state == CHK_IDLE);
        cmp_valid = 1'b0;
        cmp_tag   = '0;
        cmp_fault = 1'b0;
        wb_data   = '0;
        unique case (state)
            CHK_IDLE: begin
                if (ld_valid && ld_hit && !flush) begin
                    cmp_valid = 1'b1;
                    cmp_tag   = ld_tag;
                    cmp_fault = !ld_perm_ok;
                    wb_data   = ld_perm_ok ? ld_data : '0;
                end
            end
            CHK_WALK: begin
                if (walk_valid && !flush) begin
                    cmp_valid = 1'b1;
                    cmp_tag   = park_tag;
                    cmp_fault = !walk_ok;
                    wb_data   = walk_ok ? park_data : '0;
                end
            end
            default: ;
        endcase
    end

    AST_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && wb_data != '0) |-> !cmp_fault); // R3
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ready && !walk_valid && !flush) |=> !ld_ready); // R5
endmodule

// File: rtl/dfr_retsel.sv
module dfr_retsel #(
    parameter int DEPTH = 8,
    parameter int RET_W = 4,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] head,
    input  logic [DEPTH-1:0] ent_v,
    input  logic [DEPTH-1:0] ent_done,
    input  logic [DEPTH-1:0] ent_flt,
    input  logic [DEPTH-1:0] ent_st,
    output logic [RET_W-1:0] ret_mask,
    output logic [RET_W-1:0] st_mask,
    output logic [CNT_W-1:0] ret_cnt
);
    logic [RET_W-1:0] lane_ok;

    for (genvar g = 0; g < RET_W; g++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx         = head + IDX_W'(g);
        assign lane_ok[g]  = ent_v[idx] & ent_done[idx] & ~ent_flt[idx];
        assign ret_mask[g] = &lane_ok[g:0];
        assign st_mask[g]  = ret_mask[g] & ent_st[idx];
    end

    always_comb begin
        ret_cnt = '0;
        for (int i = 0; i < RET_W; i++) ret_cnt = ret_cnt + CNT_W'(ret_mask[i]);
    end

    AST_STORE_ONLY_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mask & ~ret_mask) == '0); // R11
    AST_RET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt <= CNT_W'(RET_W)); // R7
endmodule

// File: rtl/dfr_rob.sv
module dfr_rob #(
    parameter int DEPTH = 8,
    parameter int RET_W = 4,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_store,
    output logic             disp_ready,
    output logic [IDX_W-1:0] disp_tag,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_tag,
    input  logic             cmp_fault,
    output logic [CNT_W-1:0] ret_cnt,
    output logic [IDX_W-1:0] ret_base_tag,
    output logic [RET_W-1:0] st_release,
    output logic             flush,
    output logic [IDX_W-1:0] exc_tag
);
    localparam int OCC_W = IDX_W + 1;

    logic [DEPTH-1:0] ent_v, ent_done, ent_flt, ent_st;
    logic [IDX_W-1:0] head, tail;
    logic [OCC_W-1:0] occ;
    logic [RET_W-1:0] ret_mask;
    logic             alloc;

    dfr_retsel #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) retsel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .head     (head),
        .ent_v    (ent_v),
        .ent_done (ent_done),
        .ent_flt  (ent_flt),
        .ent_st   (ent_st),
        .ret_mask (ret_mask),
        .st_mask  (st_release),
        .ret_cnt  (ret_cnt)
    );

    assign flush        = ent_v[head] & ent_done[head] & ent_flt[head];
    assign exc_tag      = head;
    assign ret_base_tag = head;
    assign disp_tag     = tail;
    assign disp_ready   = (occ != OCC_W'(DEPTH)) && !flush;
    assign alloc        = disp_valid && disp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v    <= '0;
            ent_done <= '0;
            ent_flt  <= '0;
            ent_st   <= '0;
            head     <= '0;
            tail     <= '0;
            occ      <= '0;
        end else if (flush) begin
            ent_v <= '0;
            tail  <= head;
            occ   <= '0;
        end else begin
            for (int i = 0; i < RET_W; i++) begin
                if (ret_mask[i]) ent_v[head + IDX_W'(i)] <= 1'b0;
            end
            if (cmp_valid && ent_v[cmp_tag] && !ent_done[cmp_tag]) begin
                ent_done[cmp_tag] <= 1'b1;
                ent_flt[cmp_tag]  <= cmp_fault;
            end
            if (alloc) begin
                ent_v[tail]    <= 1'b1;
                ent_done[tail] <= disp_store;
                ent_flt[tail]  <= 1'b0;
                ent_st[tail]   <= disp_store;
                tail           <= tail + IDX_W'(1);
            end
            head <= head + IDX_W'(ret_cnt);
            occ  <= occ + OCC_W'(alloc) - OCC_W'(ret_cnt);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH)); // R2
    AST_FAULT_NOT_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (ret_cnt == '0)); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_release == '0 && ret_cnt == '0)); // R10
endmodule

// File: rtl/defer_fault_rob.sv
module defer_fault_rob
    import dfr_pkg::*;
#(
    parameter int  DEPTH  = DFR_DEPTH_DEF,
    parameter int  RET_W  = DFR_RET_W_DEF,
    parameter int  DATA_W = DFR_DATA_W_DEF,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(RET_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_store,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_tag,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [IDX_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_hit,
    input  logic              ld_perm_ok,
    input  logic              walk_valid,
    input  logic              walk_ok,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data,
    output logic [CNT_W-1:0]  ret_cnt,
    output logic [IDX_W-1:0]  ret_base_tag,
    output logic [RET_W-1:0]  st_release,
    output logic              exc_valid,
    output logic [IDX_W-1:0]  exc_tag
);
    logic             flush;
    logic             cmp_valid;
    logic [IDX_W-1:0] cmp_tag;
    logic             cmp_fault;

    dfr_ldchk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) ldchk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .ld_valid   (ld_valid),
        .ld_ready   (ld_ready),
        .ld_tag     (ld_tag),
        .ld_data    (ld_data),
        .ld_hit     (ld_hit),
        .ld_perm_ok (ld_perm_ok),
        .walk_valid (walk_valid),
        .walk_ok    (walk_ok),
        .cmp_valid  (cmp_valid),
        .cmp_tag    (cmp_tag),
        .cmp_fault  (cmp_fault),
        .wb_data    (wb_data)
    );

    dfr_rob #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) rob_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_valid   (disp_valid),
        .disp_store   (disp_store),
        .disp_ready   (disp_ready),
        .disp_tag     (disp_tag),
        .cmp_valid    (cmp_valid),
        .cmp_tag      (cmp_tag),
        .cmp_fault    (cmp_fault),
        .ret_cnt      (ret_cnt),
        .ret_base_tag (ret_base_tag),
        .st_release   (st_release),
        .flush        (flush),
        .exc_tag      (exc_tag)
    );

    assign wb_valid  = cmp_valid;
    assign wb_tag    = cmp_tag;
    assign exc_valid = flush;

    AST_EXC_BLOCKS_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !disp_ready); // R10
endmodule

// File: tb/defer_fault_rob_tb_top.sv
module defer_fault_rob_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        disp_valid = 0, disp_store = 0, disp_ready;
    logic [2:0]  disp_tag;
    logic        ld_valid = 0, ld_ready, ld_hit = 0, ld_perm_ok = 0;
    logic [2:0]  ld_tag = '0;
    logic [31:0] ld_data = '0;
    logic        walk_valid = 0, walk_ok = 0;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [31:0] wb_data;
    logic [2:0]  ret_cnt, ret_base_tag, exc_tag;
    logic [3:0]  st_release;
    logic        exc_valid;

    defer_fault_rob dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_store(disp_store), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_tag(ld_tag), .ld_data(ld_data),
        .ld_hit(ld_hit), .ld_perm_ok(ld_perm_ok), .walk_valid(walk_valid), .walk_ok(walk_ok),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .ret_cnt(ret_cnt), .ret_base_tag(ret_base_tag), .st_release(st_release),
        .exc_valid(exc_valid), .exc_tag(exc_tag)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic dispatch(input logic st, input logic [2:0] exp_tag, input string req);
        disp_valid = 1'b1;
        disp_store = st;
        #1;
        chk(req, "disp_ready", disp_ready, 1);
        chk(req, "disp_tag", disp_tag, exp_tag);
        step;
        disp_valid = 1'b0;
        disp_store = 1'b0;
    endtask

    task automatic hit_load(input logic [2:0] tag, input logic [31:0] data, input logic perm,
                            input logic [31:0] exp_data, input string req);
        ld_valid = 1'b1; ld_hit = 1'b1; ld_perm_ok = perm; ld_tag = tag; ld_data = data;
        #1;
        chk(req, "ld_ready", ld_ready, 1);
        chk(req, "wb_valid", wb_valid, 1);
        chk(req, "wb_tag", wb_tag, tag);
        chk(req, "wb_data", wb_data, exp_data);
        step;
        ld_valid = 1'b0; ld_hit = 1'b0; ld_perm_ok = 1'b0;
    endtask

    task automatic miss_load(input logic [2:0] tag, input logic [31:0] data, input logic ok,
                             input logic [31:0] exp_data, input string req);
        ld_valid = 1'b1; ld_hit = 1'b0; ld_tag = tag; ld_data = data;
        #1;
        chk(req, "wb_valid on miss", wb_valid, 0);
        step;
        ld_valid = 1'b0;
        chk(req, "ld_ready waiting", ld_ready, 0);
        step;
        chk(req, "ld_ready still waiting", ld_ready, 0);
        chk(req, "no early wb", wb_valid, 0);
        walk_valid = 1'b1; walk_ok = ok;
        #1;
        chk(req, "wb_valid at walk", wb_valid, 1);
        chk(req, "wb_tag at walk", wb_tag, tag);
        chk(req, "wb_data at walk", wb_data, exp_data);
        step;
        walk_valid = 1'b0; walk_ok = 1'b0;
        chk(req, "ld_ready after walk", ld_ready, 1);
    endtask

    // reset values
    task automatic t_reset;
        chk("R1", "disp_ready", disp_ready, 1);
        chk("R1", "ld_ready", ld_ready, 1);
        chk("R1", "ret_cnt", ret_cnt, 0);
        chk("R1", "exc_valid", exc_valid, 0);
        chk("R1", "disp_tag", disp_tag, 0);
    endtask

    // grouped retirement, store release timing
    task automatic t_group_retire;
        dispatch(1'b0, 3'd0, "R1");
        dispatch(1'b1, 3'd1, "R1");
        dispatch(1'b1, 3'd2, "R1");
        dispatch(1'b0, 3'd3, "R1");
        dispatch(1'b1, 3'd4, "R1");
        chk("R7", "ret_cnt head incomplete", ret_cnt, 0);
        chk("R11", "no early store release", st_release, 0);
        hit_load(3'd3, 32'h1234, 1'b1, 32'h1234, "R4");
        chk("R7", "ret_cnt still blocked", ret_cnt, 0);
        hit_load(3'd0, 32'hABCD, 1'b1, 32'hABCD, "R4");
        chk("R7", "ret_cnt capped", ret_cnt, 4);
        chk("R7", "ret_base_tag", ret_base_tag, 0);
        chk("R11", "st_release group", st_release, 4'b0110);
        step;
        chk("R7", "ret_cnt tail", ret_cnt, 1);
        chk("R7", "ret_base_tag tail", ret_base_tag, 4);
        chk("R11", "st_release tail", st_release, 4'b0001);
        step;
        chk("R7", "ret_cnt empty", ret_cnt, 0);
    endtask

    // denied hit deferred to head, flush
    task automatic t_deferred_fault;
        dispatch(1'b0, 3'd5, "R1");
        dispatch(1'b0, 3'd6, "R1");
        dispatch(1'b1, 3'd7, "R1");
        hit_load(3'd6, 32'hFFFF, 1'b0, 32'h0, "R3");
        chk("R8", "exc not at head", exc_valid, 0);
        chk("R8", "ret_cnt behind incomplete", ret_cnt, 0);
        hit_load(3'd5, 32'h55, 1'b1, 32'h55, "R4");
        chk("R8", "older retires first", ret_cnt, 1);
        chk("R8", "older base", ret_base_tag, 5);
        chk("R8", "no exc yet", exc_valid, 0);
        step;
        chk("R8", "exc_valid", exc_valid, 1);
        chk("R8", "exc_tag", exc_tag, 6);
        chk("R8", "ret_cnt in exc", ret_cnt, 0);
        chk("R10", "disp_ready in exc", disp_ready, 0);
        chk("R10", "store discarded", st_release, 0);
        step;
        chk("R10", "exc cleared", exc_valid, 0);
        chk("R10", "nothing retires", ret_cnt, 0);
        chk("R10", "store still not released", st_release, 0);
        dispatch(1'b0, 3'd6, "R10");
        hit_load(3'd6, 32'h66, 1'b1, 32'h66, "R4");
        chk("R7", "reused tag retires", ret_cnt, 1);
        chk("R7", "reused tag base", ret_base_tag, 6);
        step;
    endtask

    // two tagged loads completing youngest first
    task automatic t_oldest_fault;
        dispatch(1'b0, 3'd7, "R1");
        dispatch(1'b0, 3'd0, "R1");
        dispatch(1'b0, 3'd1, "R1");
        hit_load(3'd1, 32'h11, 1'b0, 32'h0, "R3");
        hit_load(3'd0, 32'h22, 1'b0, 32'h0, "R3");
        chk("R9", "exc waits for oldest", exc_valid, 0);
        hit_load(3'd7, 32'h77, 1'b1, 32'h77, "R4");
        chk("R9", "oldest retires", ret_cnt, 1);
        chk("R9", "no exc in retire cycle", exc_valid, 0);
        step;
        chk("R9", "exc_valid", exc_valid, 1);
        chk("R9", "exc names oldest tagged", exc_tag, 0);
        step;
        chk("R9", "single exception", exc_valid, 0);
    endtask

    // translation miss, walk success and failure
    task automatic t_walk;
        dispatch(1'b0, 3'd0, "R10");
        dispatch(1'b0, 3'd1, "R1");
        miss_load(3'd0, 32'h5555, 1'b1, 32'h5555, "R5");
        chk("R5", "walked load retires", ret_cnt, 1);
        chk("R5", "walked base", ret_base_tag, 0);
        step;
        miss_load(3'd1, 32'h7777, 1'b0, 32'h0, "R6");
        chk("R6", "failed walk faults at head", exc_valid, 1);
        chk("R6", "failed walk tag", exc_tag, 1);
        step;
        chk("R6", "exc done", exc_valid, 0);
    endtask

    // full buffer
    task automatic t_full;
        for (int i = 0; i < 8; i++) dispatch(1'b0, 3'(1 + i), "R2");
        chk("R2", "disp_ready full", disp_ready, 0);
        disp_valid = 1'b1; disp_store = 1'b1;
        step;
        disp_valid = 1'b0; disp_store = 1'b0;
        chk("R2", "still full", disp_ready, 0);
        for (int i = 7; i >= 0; i--) hit_load(3'(1 + i), 32'(i + 1), 1'b1, 32'(i + 1), "R4");
        chk("R2", "first group", ret_cnt, 4);
        chk("R2", "first base", ret_base_tag, 1);
        step;
        chk("R2", "second group", ret_cnt, 4);
        chk("R2", "second base", ret_base_tag, 5);
        step;
        chk("R2", "rejected store absent", ret_cnt, 0);
        chk("R2", "ready again", disp_ready, 1);
    endtask

    initial begin
        step;
        step;
        rst_n = 1'b1;
        step;
        t_reset;
        t_group_retire;
        t_deferred_fault;
        t_oldest_fault;
        t_walk;
        t_full;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule